// File: doc/BRIEF.md
# One-Shot Memory Fill Sequencer

This block pairs a small synchronous RAM with a controller that fills it exactly once after every reset. When reset is released, the controller writes one location per clock in ascending address order. The word it stores equals the index of that write within the pass, so location N ends up holding N. Once the highest location has been written, the controller stops writing for good. It parks the fill address on the last location and keeps the RAM in read mode until the next reset.

The stop decision comes from the address count alone. A registered completion flag is set on the very clock edge that performs the final write, and write enable is the inverse of that flag. The last location is therefore written before writing shuts off, and no clock is ever gated. A separate read port returns the word at any requested address one cycle later, whether or not the fill has finished. Reset may arrive at any moment. It clears the counters and the flag at once and starts a fresh pass.

Top module: `fill_once_ram`

## Requirements
- R1: While `rst` is high, `fillAddr` reads 0 and `done` reads 0. Asserting `rst` clears both at once, without waiting for a clock edge.
- R2: On each rising edge of `clk` with `rst` low and `done` at 0, the location at `fillAddr` is written and `fillAddr` advances by one, except when it is at the last location. The word written to location N is N.
- R3: `done` goes to 1 on the edge that writes the last location (2^ADDR_W - 1), which is the 16th edge after reset release with the default 4-bit address. It is still 0 after the 15th edge, and the last location holds its value once the pass ends.
- R4: Once `done` is 1, no further writes occur. `fillAddr` stays at the last location without wrapping, and `done` stays at 1 until the next reset.
- R5: After a completed pass, every location N reads back the value N, and extra clocks leave the contents unchanged.
- R6: `rdData` presents the word stored at `rdAddr` one clock edge after `rdAddr` is applied. This holds during the fill as well as after it.
- R7: A reset applied partway through a pass restarts the fill from location 0. The following pass takes the full count of edges to finish and leaves every location N holding N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high reset, asynchronous assertion |
| rdAddr | input | ADDR_W | Address of the word to read back |
| rdData | output | DATA_W | Word at `rdAddr`, one cycle later |
| fillAddr | output | ADDR_W | Location the controller writes next (last location once done) |
| done | output | 1 | High once every location has been written in this pass |

## Verification
The bound checker checks the counter behaviour on every cycle. It confirms that the fill address steps by one while filling, that completion is flagged on the edge that leaves the last location, that the address and flag hold once the pass is done, and that reset holds both at zero. What was actually stored cannot be seen by a property without a memory model, so only the bench's scenarios show it. These scenarios read back each location during the fill and after it, run extra clocks after completion, and apply an asynchronous reset partway through a pass.

// File: rtl/fill_pkg.sv
package fill_pkg;
  // Strobes from the control to the datapath.
  typedef struct packed {
    logic wrEn;  // write the current location this cycle
    logic step;  // advance address and data counters
  } fill_strobe_t;
endpackage

// File: rtl/fill_ctrl.sv
module fill_ctrl
  import fill_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fillAddr,
  output fill_strobe_t      strb,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  logic atLast;

  // Terminal count is taken from the address alone.
  assign atLast = (fillAddr == LAST_ADDR);

  // The flag is set by the same edge that writes the last location.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      done <= 1'b0;
    end else if (strb.wrEn && atLast) begin
      done <= 1'b1;
    end
  end

  always_comb begin
    strb.wrEn = ~done;
    strb.step = ~done & ~atLast;
  end
endmodule

// File: rtl/fill_datapath.sv
module fill_datapath
  import fill_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  fill_strobe_t      strb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] fillAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] fillData;
  logic [DATA_W-1:0] mem [DEPTH];

  // Address and data counters advance together.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      fillAddr <= '0;
      fillData <= '0;
    end else if (strb.step) begin
      fillAddr <= fillAddr + 1'b1;
      fillData <= fillData + 1'b1;
    end
  end

  // Synchronous RAM with a registered read port.
  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      mem[fillAddr] <= fillData;
    end
    rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/fill_once_ram.sv
module fill_once_ram
  import fill_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] fillAddr,
  output logic              done
);
  fill_strobe_t strb;

  fill_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .fillAddr(fillAddr),
    .strb    (strb),
    .done    (done)
  );

  fill_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .rdAddr  (rdAddr),
    .fillAddr(fillAddr),
    .rdData  (rdData)
  );
endmodule

// File: rtl/fill_once_ram_chk.sv
module fill_once_ram_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] fillAddr,
  input logic              done
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  // R1: reset holds counters and flag clear
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |-> (fillAddr == '0 && !done));

  // R2: one step per clock while filling
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!done && fillAddr != LAST_ADDR) |=>
      (!done && fillAddr == ADDR_W'($past(fillAddr) + 1'b1)));

  // R3: completion on the edge that leaves the last location
  p_finish_r3: assert property (@(posedge clk) disable iff (rst)
    (!done && fillAddr == LAST_ADDR) |=> (done && fillAddr == LAST_ADDR));

  // R4: once complete, nothing moves
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(fillAddr)));

  // R4: no wrap past the last location
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (fillAddr == LAST_ADDR));
endmodule

bind fill_once_ram fill_once_ram_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .fillAddr(fillAddr),
  .done    (done)
);

// File: tb/fill_once_ram_tb_top.sv
`timescale 1ns/100ps
module fill_once_ram_tb_top;
  localparam int AW = 4;
  localparam int DW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] rdAddr;
  logic [DW-1:0] rdData;
  logic [AW-1:0] fillAddr;
  logic          done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // Scoreboard queues
  int    qAddr[$];
  int    qExp[$];
  int    qDue[$];
  string qReq[$];

  fill_once_ram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .rdAddr(rdAddr), .rdData(rdData),
    .fillAddr(fillAddr), .done(done)
  );

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc++;

  task automatic check(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Driver: apply a read address at a negedge, queue the expected word.
  task automatic stepRead(int a, int e, string req);
    rdAddr = a[AW-1:0];
    qAddr.push_back(a);
    qExp.push_back(e);
    qDue.push_back(cyc + 1);
    qReq.push_back(req);
    @(posedge clk);
    @(negedge clk);
  endtask

  // Monitor: compare read data in the cycle it is due.
  always @(negedge clk) begin
    while (qDue.size() > 0 && qDue[0] == cyc) begin
      check(int'(rdData) == qExp[0], qReq[0], int'(rdData), qExp[0],
            $sformatf("rdData at location %0d", qAddr[0]));
      void'(qAddr.pop_front());
      void'(qExp.pop_front());
      void'(qDue.pop_front());
      void'(qReq.pop_front());
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 5000, "run did not finish");
    summary();
  end

  initial begin
    int k;
    rst = 1'b1;
    rdAddr = '0;
    repeat (3) @(negedge clk);
    check(fillAddr == '0, "R1", fillAddr, 0, "fillAddr in reset");
    check(done == 1'b0, "R1", done, 0, "done in reset");

    // First pass
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    for (int j = 1; j < DEPTH; j++) begin
      check(int'(fillAddr) == j, "R2", fillAddr, j, "fillAddr during fill");
      check(done == 1'b0, "R3", done, 0, "done before last write");
      stepRead(j - 1, j - 1, "R6");  // read back during fill
    end
    check(done == 1'b1, "R3", done, 1, "done after 16th edge");
    check(int'(fillAddr) == DEPTH - 1, "R3", fillAddr, DEPTH - 1, "fillAddr at end");
    stepRead(DEPTH - 1, DEPTH - 1, "R3");  // last location not lost

    // Extra clocks change nothing
    repeat (40) @(negedge clk);
    check(done == 1'b1, "R4", done, 1, "done holds");
    check(int'(fillAddr) == DEPTH - 1, "R4", fillAddr, DEPTH - 1, "no wrap");
    for (int a = 0; a < DEPTH; a++) stepRead(a, a, "R5");

    // Second pass, interrupted by an asynchronous reset
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    check(int'(fillAddr) == 6, "R2", fillAddr, 6, "fillAddr mid pass");
    #0.5 rst = 1'b1;
    #0.5;
    check(fillAddr == '0, "R1", fillAddr, 0, "async clear of fillAddr");
    check(done == 1'b0, "R1", done, 0, "async clear of done");
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(int'(fillAddr) == 1, "R7", fillAddr, 1, "restart from location 0");
    k = 1;
    while (!done && k < 40) begin
      @(negedge clk);
      k++;
    end
    check(k == DEPTH, "R7", k, DEPTH, "edges to complete restarted pass");
    for (int a = 0; a < DEPTH; a++) stepRead(a, a, "R7");

    @(negedge clk);
    @(negedge clk);
    check(qDue.size() == 0, "R6", qDue.size(), 0, "pending reads left");
    summary();
  end
endmodule